// File: doc/BRIEF.md
# Self-Test Sequencer for a Security Controller

This block runs the control side of a built-in self-test. Software sets an enable level. When the controller is in a state that permits testing, the block starts an external test engine with a one-cycle start pulse. It then publishes four status bits (active, running, pass, fail) and a busy flag. It also waits for an initialization handshake that brings the controller back to a ready state. The test algorithm, the register bus and any software timeout sit outside this block. The engine and the initialization routine connect as simple request/done ports.

The block proves that its result bits are not stuck. When the engine finishes, both the pass bit and the fail bit go high. The verdict appears only after software clears the enable: one of the two bits then drops, and the other stays high. If both stay high, the engine gave no usable verdict. Once a test has started, nothing except the controller reset stops it. A zeroize request that arrives while a test is pending, running or waiting for the enable to clear is discarded. It is not held for later.

Top module: `stest_seq`

## Requirements
- R1: After reset, active, running, pass, fail and busy are all 0, and no start, initialization or zeroize pulse is issued.
- R2: With enable=1 and allowed=1 in an idle or initialized state, the next clock edge raises active and running, clears pass and fail, and drives eng_start high for exactly one cycle.
- R3: With enable=1 while allowed=0, no test starts. The test starts on the clock edge that first samples allowed=1. If enable falls before that, the request is cancelled.
- R4: While a test runs, changes on enable, allowed and zeroize_req have no effect. The test ends only on eng_done, and no zeroize_go pulse is produced.
- R5: On the clock edge that samples eng_done, active goes to 0, pass and fail both go to 1, and running stays 1.
- R6: While enable stays 1 after completion, pass and fail both stay 1. On the edge that samples enable=0, a pass verdict (eng_valid=1, eng_pass=1) clears fail, and a fail verdict (eng_valid=1, eng_pass=0) clears pass.
- R7: If eng_valid=0 when eng_done is sampled, pass and fail both stay 1 after enable is cleared.
- R8: On the edge where the verdict is shown, running goes to 0, busy goes to 1 and init_req pulses for one cycle. Busy falls on the edge that samples init_done. Pass and fail keep their values throughout.
- R9: From the initialized state, a new enable=1 starts a fresh test and clears the previous verdict.
- R10: A zeroize_req sampled in the idle or initialized state with enable=0 produces a one-cycle zeroize_go on the next cycle. In any other state the request is dropped and is not replayed later.
- R11: Asserting reset during a test aborts it and clears every status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| en | input | 1 | Software self-test enable level |
| allowed | input | 1 | High when the controller state permits a test |
| zeroize_req | input | 1 | Zeroize command, sampled each cycle |
| eng_done | input | 1 | Test engine finished (pulse) |
| eng_pass | input | 1 | Engine verdict, meaningful with eng_done |
| eng_valid | input | 1 | Engine verdict is valid, meaningful with eng_done |
| init_done | input | 1 | Initialization routine finished (pulse) |
| eng_start | output | 1 | One-cycle start pulse to the test engine |
| init_req | output | 1 | One-cycle initialization request |
| zeroize_go | output | 1 | One-cycle accepted-zeroize pulse |
| st_active | output | 1 | Test in progress |
| st_running | output | 1 | Test sequence not yet handed back to initialization |
| st_pass | output | 1 | Pass status bit |
| st_fail | output | 1 | Fail status bit |
| busy | output | 1 | Initialization in progress |

## Verification
The block has no parameters: every signal is one bit wide and the state encoding is fixed. A single default elaboration therefore reaches every state and transition. The bench walks that build through passing, failing and invalid verdicts, a request that waits on the permission input and one that is cancelled, zeroize attempts both inside and outside the test, and a reset that lands mid-test.

// File: rtl/stest_pkg.sv
package stest_pkg;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_PENDING = 3'd1,
    S_RUN     = 3'd2,
    S_WAITCLR = 3'd3,
    S_REINIT  = 3'd4,
    S_READY   = 3'd5
  } st_state_e;

  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_OK   = 2'd1,
    RES_BAD  = 2'd2
  } st_res_e;

  // Turn the engine outputs into a verdict code.
  function automatic st_res_e classify(input logic valid, input logic pass);
    if (!valid)    return RES_NONE;
    else if (pass) return RES_OK;
    else           return RES_BAD;
  endfunction

  // Flag pair {pass, fail} once the verdict is revealed.
  function automatic logic [1:0] reveal(input st_res_e res);
    case (res)
      RES_OK:  return 2'b10;
      RES_BAD: return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/stest_fsm.sv
module stest_fsm
  import stest_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic allowed,
  input  logic zeroize_req,
  input  logic eng_done,
  input  logic init_done,
  output logic ev_start,
  output logic ev_finish,
  output logic ev_show,
  output logic ev_ready,
  output logic eng_start,
  output logic init_req,
  output logic zeroize_go
);

  st_state_e state_q, state_d;
  logic      home_ready_q;
  logic      at_rest;
  logic      ev_zero;
  st_state_e home;

  assign at_rest   = (state_q == S_IDLE) || (state_q == S_READY);
  assign home      = home_ready_q ? S_READY : S_IDLE;
  assign ev_start  = (at_rest || state_q == S_PENDING) && en && allowed;
  assign ev_finish = (state_q == S_RUN) && eng_done;
  assign ev_show   = (state_q == S_WAITCLR) && !en;
  assign ev_ready  = (state_q == S_REINIT) && init_done;
  assign ev_zero   = at_rest && !en && zeroize_req;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE, S_READY: begin
        if (en) state_d = allowed ? S_RUN : S_PENDING;
      end
      S_PENDING: begin
        if (!en)         state_d = home;
        else if (allowed) state_d = S_RUN;
      end
      S_RUN:     if (eng_done)  state_d = S_WAITCLR;
      S_WAITCLR: if (!en)       state_d = S_REINIT;
      S_REINIT:  if (init_done) state_d = S_READY;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      home_ready_q <= 1'b0;
      eng_start    <= 1'b0;
      init_req     <= 1'b0;
      zeroize_go   <= 1'b0;
    end else begin
      state_q    <= state_d;
      eng_start  <= ev_start;
      init_req   <= ev_show;
      zeroize_go <= ev_zero;
      if (ev_ready) home_ready_q <= 1'b1;
    end
  end

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  assert_start_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> ($past(allowed) && $past(en)));

  assert_zero_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    zeroize_go |-> !$past(en));

  assert_init_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> !init_req);

endmodule

// File: rtl/stest_flags.sv
module stest_flags
  import stest_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ev_start,
  input  logic ev_finish,
  input  logic ev_show,
  input  logic ev_ready,
  input  logic eng_pass,
  input  logic eng_valid,
  output logic st_active,
  output logic st_running,
  output logic st_pass,
  output logic st_fail,
  output logic busy
);

  st_res_e    res_q;
  logic [1:0] shown;

  assign shown = reveal(res_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_active  <= 1'b0;
      st_running <= 1'b0;
      st_pass    <= 1'b0;
      st_fail    <= 1'b0;
      busy       <= 1'b0;
      res_q      <= RES_NONE;
    end else begin
      if (ev_start) begin
        st_active  <= 1'b1;
        st_running <= 1'b1;
        st_pass    <= 1'b0;
        st_fail    <= 1'b0;
      end
      if (ev_finish) begin
        st_active <= 1'b0;
        st_pass   <= 1'b1;
        st_fail   <= 1'b1;
        res_q     <= classify(eng_valid, eng_pass);
      end
      if (ev_show) begin
        st_running <= 1'b0;
        busy       <= 1'b1;
        st_pass    <= shown[1];
        st_fail    <= shown[0];
      end
      if (ev_ready) busy <= 1'b0;
    end
  end

  assert_finish_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_active) |-> (st_pass && st_fail && st_running));

  assert_hold_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(st_pass) && $stable(st_fail)));

  assert_no_busy_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && st_active));

  assert_fresh_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_active) |-> (!st_pass && !st_fail));

endmodule

// File: rtl/stest_seq.sv
module stest_seq
  import stest_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic allowed,
  input  logic zeroize_req,
  input  logic eng_done,
  input  logic eng_pass,
  input  logic eng_valid,
  input  logic init_done,
  output logic eng_start,
  output logic init_req,
  output logic zeroize_go,
  output logic st_active,
  output logic st_running,
  output logic st_pass,
  output logic st_fail,
  output logic busy
);

  logic ev_start, ev_finish, ev_show, ev_ready;

  stest_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .allowed     (allowed),
    .zeroize_req (zeroize_req),
    .eng_done    (eng_done),
    .init_done   (init_done),
    .ev_start    (ev_start),
    .ev_finish   (ev_finish),
    .ev_show     (ev_show),
    .ev_ready    (ev_ready),
    .eng_start   (eng_start),
    .init_req    (init_req),
    .zeroize_go  (zeroize_go)
  );

  stest_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_start   (ev_start),
    .ev_finish  (ev_finish),
    .ev_show    (ev_show),
    .ev_ready   (ev_ready),
    .eng_pass   (eng_pass),
    .eng_valid  (eng_valid),
    .st_active  (st_active),
    .st_running (st_running),
    .st_pass    (st_pass),
    .st_fail    (st_fail),
    .busy       (busy)
  );

  assert_zero_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_running |-> !zeroize_go);

  assert_busy_with_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> init_req);

  assert_start_with_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (st_active && st_running));

endmodule

// File: tb/stest_seq_bench.sv
module stest_seq_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, allowed = 1'b0, zeroize_req = 1'b0;
  logic eng_done = 1'b0, eng_pass = 1'b0, eng_valid = 1'b0, init_done = 1'b0;
  logic eng_start, init_req, zeroize_go;
  logic st_active, st_running, st_pass, st_fail, busy;

  int checks = 0;
  int fails = 0;
  int zgo_count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stest_seq u_stest_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .allowed(allowed),
    .zeroize_req(zeroize_req), .eng_done(eng_done), .eng_pass(eng_pass),
    .eng_valid(eng_valid), .init_done(init_done), .eng_start(eng_start),
    .init_req(init_req), .zeroize_go(zeroize_go), .st_active(st_active),
    .st_running(st_running), .st_pass(st_pass), .st_fail(st_fail), .busy(busy)
  );

  always @(negedge clk) if (zeroize_go) zgo_count++;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // {active, running, pass, fail, busy}
  function automatic int flags();
    return {st_active, st_running, st_pass, st_fail, busy};
  endfunction

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    en = 0; allowed = 0; zeroize_req = 0; eng_done = 0; eng_pass = 0;
    eng_valid = 0; init_done = 0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic engine_done(input logic v, input logic p);
    eng_done = 1; eng_valid = v; eng_pass = p;
    tick();
    eng_done = 0; eng_valid = 0; eng_pass = 0;
  endtask

  task automatic finish_init();
    init_done = 1;
    tick();
    init_done = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "flags after reset", flags(), 0);
    check("R1", "pulses after reset", {eng_start, init_req, zeroize_go}, 0);
  endtask

  task automatic t_pass_flow();
    int z0;
    z0 = zgo_count;
    en = 1; allowed = 1;
    tick();
    check("R2", "start flags", flags(), 5'b11000);
    check("R2", "eng_start high", eng_start, 1);
    allowed = 0;
    tick();
    check("R2", "eng_start one cycle", eng_start, 0);
    zeroize_req = 1; en = 0;
    tick();
    zeroize_req = 0;
    tick();
    check("R4", "still running after enable drop and zeroize", flags(), 5'b11000);
    check("R4", "zeroize dropped during run", zgo_count - z0, 0);
    en = 1;
    engine_done(1, 1);
    check("R5", "finish flags", flags(), 5'b01110);
    tick(); tick();
    check("R6", "both held while enable=1", flags(), 5'b01110);
    en = 0;
    tick();
    check("R6", "pass verdict shown", flags(), 5'b00101);
    check("R8", "init_req pulse", init_req, 1);
    tick();
    check("R8", "init_req one cycle", init_req, 0);
    check("R8", "busy during init", busy, 1);
    finish_init();
    check("R8", "busy cleared, result kept", flags(), 5'b00100);
    check("R10", "zeroize not replayed", zgo_count - z0, 0);
  endtask

  task automatic t_fail_flow();
    en = 1; allowed = 1;
    tick();
    check("R9", "fresh start clears old result", flags(), 5'b11000);
    engine_done(1, 0);
    en = 0;
    tick();
    check("R6", "fail verdict shown", flags(), 5'b00011);
    finish_init();
    check("R8", "fail result kept", flags(), 5'b00010);
  endtask

  task automatic t_invalid();
    en = 1; allowed = 1;
    tick();
    engine_done(0, 1);
    en = 0;
    tick();
    check("R7", "invalid keeps both high", flags(), 5'b00111);
    finish_init();
    check("R7", "both high after init", flags(), 5'b00110);
  endtask

  task automatic t_pending();
    allowed = 0; en = 1;
    tick(); tick(); tick();
    check("R3", "no start while not allowed", {eng_start, st_active}, 0);
    allowed = 1;
    tick();
    check("R3", "start once allowed", {eng_start, st_active}, 2'b11);
    engine_done(1, 1);
    en = 0;
    tick();
    finish_init();
    allowed = 0; en = 1;
    tick();
    en = 0;
    tick();
    allowed = 1;
    tick(); tick();
    check("R3", "cancelled request stays idle", {eng_start, st_active}, 0);
  endtask

  task automatic t_zeroize();
    int z0;
    z0 = zgo_count;
    en = 0;
    zeroize_req = 1;
    tick();
    zeroize_req = 0;
    check("R10", "zeroize accepted when ready", zeroize_go, 1);
    tick();
    check("R10", "zeroize one cycle", zeroize_go, 0);
    check("R10", "single accepted pulse", zgo_count - z0, 1);
  endtask

  task automatic t_abort();
    en = 1; allowed = 1;
    tick(); tick();
    rst_n = 0;
    #1;
    check("R11", "reset clears flags mid-run", flags(), 0);
    en = 0; allowed = 0;
    tick();
    rst_n = 1;
    eng_done = 1; eng_valid = 1; eng_pass = 1;
    tick();
    eng_done = 0; eng_valid = 0; eng_pass = 0;
    tick();
    check("R11", "late engine done ignored after reset", flags(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    finish_up();
  end

  initial begin
    t_reset();
    t_pass_flow();
    t_fail_flow();
    t_invalid();
    t_pending();
    t_zeroize();
    t_abort();
    finish_up();
  end

endmodule